// File: doc/BRIEF.md
# Shadowed Baud Divisor Register

This block holds the 13-bit divisor that sets the bit rate of a serial port. It also produces the baud tick that the divisor governs. Software reaches it as one 16-bit register on a simple write bus with two byte-lane strobes. A write that covers both lanes replaces the divisor at once. The register can also be loaded one byte at a time, and the hardware stages those byte writes so that the divisor only ever moves from one complete value to another. A write to the upper lane alone goes into a hidden holding byte and marks it as armed. The next lower-lane write then commits the lower byte and the held upper byte in the same clock. If a lower-lane write arrives with nothing armed, the upper part of the divisor is cleared to zero.

The read port always shows the committed value, with the three top bits forced to zero. A down-counter reloads from the committed divisor and pulses a one-cycle tick each time it runs out, so the tick period in clocks equals the divisor. A new divisor takes effect at the next reload. When the divisor is zero the tick stays low.

Top module: `baud_divisor_reg`

## Requirements
- R1: After a synchronous reset `rd_data` reads 0x0004, and the tick repeats every 4 clocks.
- R2: `rd_data[15:13]` always reads zero, and any ones written to those positions, whether directly or through the held upper byte, are dropped.
- R3: A write with `wr_strb` = 2'b10 (upper lane only, `wr_data[15:8]`) leaves `rd_data` unchanged.
- R4: A write with `wr_strb` = 2'b01 (lower lane only, `wr_data[7:0]`) that follows an upper-only write commits the new lower byte together with the held upper byte in the same clock.
- R5: A lower-only write with no armed upper byte loads zero into the upper part. Every lower-only write disarms the held byte.
- R6: A write with `wr_strb` = 2'b11 loads `wr_data[12:0]` in one clock and disarms any held upper byte.
- R7: A second upper-only write before the commit replaces the held byte. The last one written is the one committed.
- R8: With a nonzero divisor N, `baud_tick` is high for one clock and then low for N-1 clocks. A divisor written mid-count takes effect from the next reload.
- R9: While the divisor is zero, `baud_tick` stays low.
- R10: A write with `wr_strb` = 2'b00, or with `wr_en` low, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for this register |
| wr_strb | input | 2 | Byte-lane enables: bit 1 = upper byte, bit 0 = lower byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Committed register value, top three bits zero |
| baud_tick | output | 1 | One-clock pulse every divisor clocks |

## Verification
The staging logic is driven with four lane patterns, each in several orders: full word, upper then lower, lower with nothing armed, and two uppers before a lower. Together they separate a design that commits early from one that forgets the armed state or keeps the armed state past a commit. Writes with all-ones data show whether the reserved bits leak through the direct path or through the held byte. The tick is measured across divisors of 4, 7, 10, 3 and 0, including a change made mid-count. These values separate off-by-one reload errors, an immediate rather than next-reload switch, and a tick that fires with a zero divisor.

// File: rtl/baud_reg_pkg.sv
package baud_reg_pkg;
    localparam int REG_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int SBR_W    = 13;
    localparam int UPPER_W  = SBR_W - BYTE_W;
    localparam int RSVD_W   = REG_W - SBR_W;

    typedef enum logic [1:0] {
        LANES_NONE = 2'b00,
        LANES_LOW  = 2'b01,
        LANES_HIGH = 2'b10,
        LANES_BOTH = 2'b11
    } lane_sel_e;

    typedef struct packed {
        logic               armed;
        logic [BYTE_W-1:0]  data;
    } hold_t;

    function automatic logic [REG_W-1:0] read_view(input logic [SBR_W-1:0] div);
        return {{RSVD_W{1'b0}}, div};
    endfunction
endpackage

// File: rtl/divisor_stage.sv
module divisor_stage
    import baud_reg_pkg::*;
#(
    parameter logic [SBR_W-1:0] RESET_DIV = 13'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  lane_sel_e         lanes,
    input  logic [REG_W-1:0]  wr_data,
    output logic [SBR_W-1:0]  div_q
);
    hold_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= RESET_DIV;
            hold_q <= '0;
        end else if (wr_en) begin
            unique case (lanes)
                LANES_BOTH: begin
                    div_q        <= wr_data[SBR_W-1:0];
                    hold_q.armed <= 1'b0;
                end
                LANES_HIGH: begin
                    hold_q.data  <= wr_data[REG_W-1:BYTE_W];
                    hold_q.armed <= 1'b1;
                end
                LANES_LOW: begin
                    div_q[BYTE_W-1:0]     <= wr_data[BYTE_W-1:0];
                    div_q[SBR_W-1:BYTE_W] <= hold_q.armed ? hold_q.data[UPPER_W-1:0]
                                                          : '0;
                    hold_q.armed          <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_upper_hidden_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lanes == LANES_HIGH) |=> $stable(div_q));

    assert_lower_commit_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lanes == LANES_LOW && hold_q.armed) |=>
            (div_q[SBR_W-1:BYTE_W] == $past(hold_q.data[UPPER_W-1:0])));

    assert_lower_unarmed_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lanes == LANES_LOW && !hold_q.armed) |=> (div_q[SBR_W-1:BYTE_W] == '0));

    assert_full_word_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lanes == LANES_BOTH) |=> (div_q == $past(wr_data[SBR_W-1:0])) && !hold_q.armed);

    assert_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || lanes == LANES_NONE) |=> $stable(div_q));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_reg_pkg::*;
#(
    parameter logic [SBR_W-1:0] RESET_DIV = 13'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SBR_W-1:0]  div,
    output logic              tick
);
    localparam logic [SBR_W-1:0] CNT_INIT = (RESET_DIV == '0) ? '0 : RESET_DIV - 1'b1;

    logic [SBR_W-1:0] cnt_q;
    logic             expired;

    assign expired = (cnt_q == '0);
    assign tick    = expired && (div != '0);

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= CNT_INIT;
        else if (div == '0)    cnt_q <= '0;
        else if (expired)      cnt_q <= div - 1'b1;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && div > 13'd1) |=> !tick);

    assert_zero_parks_R9: assert property (@(posedge clk) disable iff (rst)
        (div == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/baud_divisor_reg.sv
module baud_divisor_reg
    import baud_reg_pkg::*;
#(
    parameter logic [SBR_W-1:0] RESET_DIV = 13'd4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_strb,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic               baud_tick
);
    logic [SBR_W-1:0] div_q;
    lane_sel_e        lanes;

    assign lanes   = lane_sel_e'(wr_strb);
    assign rd_data = read_view(div_q);

    divisor_stage #(.RESET_DIV(RESET_DIV)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .lanes   (lanes),
        .wr_data (wr_data),
        .div_q   (div_q)
    );

    baud_tick_gen #(.RESET_DIV(RESET_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .div  (div_q),
        .tick (baud_tick)
    );

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[REG_W-1:SBR_W] == '0));
endmodule

// File: tb/test_baud_divisor_reg.sv
module test_baud_divisor_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_strb = 2'b00;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        baud_tick;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    baud_divisor_reg i_baud_divisor_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_strb   (wr_strb),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .baud_tick (baud_tick)
    );

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    task automatic bus_write(input logic [1:0] strb, input logic [15:0] data, input logic en = 1'b1);
        @(negedge clk);
        wr_en   = en;
        wr_strb = strb;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_strb = 2'b00;
        wr_data = 16'h0000;
    endtask

    task automatic wait_tick();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (baud_tick) return;
        end
    endtask

    task automatic tick_gap(output int gap);
        gap = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            gap++;
            if (baud_tick) return;
        end
    endtask

    task automatic t_reset();
        int gap;
        check("R1 reset value", rd_data, 16'h0004);
        wait_tick();
        tick_gap(gap);
        check("R1 reset tick period", gap, 4);
    endtask

    task automatic t_full_word();
        bus_write(2'b11, 16'hFFFF);
        check("R6/R2 full word all ones", rd_data, 16'h1FFF);
        bus_write(2'b11, 16'h1234);
        check("R6 full word", rd_data, 16'h1234);
    endtask

    task automatic t_upper_then_lower();
        bus_write(2'b11, 16'h0ABC);
        bus_write(2'b10, 16'hFF00);
        check("R3 upper-only write hidden", rd_data, 16'h0ABC);
        bus_write(2'b01, 16'h0055);
        check("R4/R2 lower commits held byte", rd_data, 16'h1F55);
        bus_write(2'b10, 16'h0300);
        bus_write(2'b01, 16'hEE21);
        check("R4 commit uses lower lane only", rd_data, 16'h0321);
    endtask

    task automatic t_lower_unarmed();
        bus_write(2'b11, 16'h1ABC);
        bus_write(2'b01, 16'h0077);
        check("R5 lower without armed upper", rd_data, 16'h0077);
        bus_write(2'b10, 16'h0600);
        bus_write(2'b01, 16'h0011);
        bus_write(2'b01, 16'h0033);
        check("R5 lower disarms held byte", rd_data, 16'h0033);
    endtask

    task automatic t_overwrite_hold();
        bus_write(2'b10, 16'h0500);
        bus_write(2'b10, 16'h0A00);
        check("R7 upper overwritten still hidden", rd_data, 16'h0033);
        bus_write(2'b01, 16'h0011);
        check("R7 last upper committed", rd_data, 16'h0A11);
    endtask

    task automatic t_full_disarms();
        bus_write(2'b10, 16'h0900);
        bus_write(2'b11, 16'h0102);
        check("R6 full word over armed byte", rd_data, 16'h0102);
        bus_write(2'b01, 16'h0044);
        check("R6 full word disarms", rd_data, 16'h0044);
    endtask

    task automatic t_no_lanes();
        bus_write(2'b11, 16'h0456);
        bus_write(2'b00, 16'hFFFF);
        check("R10 no lanes no effect", rd_data, 16'h0456);
        bus_write(2'b11, 16'h1111, 1'b0);
        check("R10 wr_en low no effect", rd_data, 16'h0456);
    endtask

    task automatic t_tick_period();
        int gap;
        bus_write(2'b11, 16'h0007);
        wait_tick();
        tick_gap(gap);
        check("R8 period 7", gap, 7);
        @(negedge clk);
        check("R8 tick one clock wide", baud_tick, 0);
        wait_tick();
        bus_write(2'b11, 16'h000A);
        wait_tick();
        tick_gap(gap);
        check("R8 new divisor after reload", gap, 10);
    endtask

    task automatic t_zero_div();
        int seen = 0;
        int gap;
        bus_write(2'b11, 16'h0000);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (baud_tick) seen++;
        end
        check("R9 no tick at zero", seen, 0);
        bus_write(2'b11, 16'h0003);
        wait_tick();
        tick_gap(gap);
        check("R9 restart period 3", gap, 3);
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full_word();
        t_upper_then_lower();
        t_lower_unarmed();
        t_overwrite_hold();
        t_full_disarms();
        t_no_lanes();
        t_tick_period();
        t_zero_div();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule